// File: doc/BRIEF.md
# Descriptor Ownership Fetch Controller

This block steers descriptor fetching for a single DMA channel. When a channel is started in descriptor mode, it reads the configuration word of the current descriptor block through a request/valid memory read port. The fetch address joins a programmable 16-bit base pointer, which forms the upper half, with a 16-bit offset. The word is stored in a configuration register, and its ownership bit is then examined. If software has handed the descriptor to the channel, the channel runs. If not, the channel parks in a halted state.

Software revives a halted channel by writing a one to the ready flag. The controller then fetches and checks the word again. The ready flag stays set until a fetch completes without error, and hardware clears it at that point. In autobuffer mode, descriptors are not used: the ready flag is inert, and a start signal moves the channel straight to running. The transfer engine reports completion through a done input.

Top module: `desc_fetch_ctrl`

## Requirements
- R1: After reset the base pointer reads 0xF003, the offset, ready flag and configuration word read 0, and the channel is idle: no memory request, not halted, not running.
- R2: While fetching, mem_req_o is held high until mem_valid_i, and mem_addr_o equals {base pointer, offset}.
- R3: A start pulse in descriptor mode from idle raises mem_req_o in the next cycle. A fetch accepted without error loads mem_rdata_i into the configuration word (register address 3, and cfg_o) on that edge.
- R4: If bit 15 of the loaded word is 1, running_o rises one cycle after the load. A done pulse while running returns the channel to idle.
- R5: If bit 15 of the loaded word is 0, halted_o rises one cycle after the load, and the channel stays halted with no request until a ready write.
- R6: In descriptor mode, a register write to address 2 with data bit 0 equal to 1 sets the ready flag. From idle or halted, it starts a fetch, with mem_req_o high in the next cycle.
- R7: A fetch that completes without error clears the ready flag, whatever bit 15 holds. A fetch answered with mem_err_i leaves the ready flag and the configuration word unchanged and puts the channel in halted.
- R8: The register map is: address 0 base pointer, 1 offset, 2 ready flag, 3 configuration word. The ready register reads 0 in bits 15:1. Writing 0 to the ready flag has no effect. Writes to address 3 are ignored.
- R9: When autobuf_i is 1, ready writes neither set the flag nor start a fetch, and a start pulse moves idle directly to running.
- R10: A ready write made while fetching, checking or running starts no further fetch, either then or later.
- R11: The check of bit 15 takes exactly one cycle between the loading edge and the entry to running or halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address for write and read |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational on reg_addr_i) |
| autobuf_i | input | 1 | 1 selects autobuffer mode, 0 descriptor mode |
| start_i | input | 1 | Channel start pulse |
| done_i | input | 1 | Transfer engine completion pulse |
| mem_req_o | output | 1 | Configuration word read request |
| mem_addr_o | output | 32 | Configuration word address |
| mem_valid_i | input | 1 | Read response valid |
| mem_err_i | input | 1 | Read response error, qualified by mem_valid_i |
| mem_rdata_i | input | 16 | Read response data |
| cfg_o | output | 16 | Configuration word register |
| halted_o | output | 1 | Channel halted on ownership or error |
| running_o | output | 1 | Channel running |

## Verification
A start or ready write sampled on one edge shows mem_req_o in the cycle that follows. A response accepted on an edge updates cfg_o and the ready flag after that same edge. running_o or halted_o follows one edge later. Register reads are combinational. The bench drives its inputs just after the rising edge. A behavioural model advances on each rising edge, and every output is compared against the model on the falling edge. Directed checks are also placed on the falling edge, at the cycle counts given above.

// File: rtl/dfc_pkg.sv
package dfc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_CHECK, ST_RUN, ST_HALT
  } dfc_st_e;

  localparam logic [1:0] RA_BASE = 2'd0;
  localparam logic [1:0] RA_OFF  = 2'd1;
  localparam logic [1:0] RA_RDY  = 2'd2;
  localparam logic [1:0] RA_CFG  = 2'd3;
endpackage

// File: rtl/dfc_regs.sv
module dfc_regs
  import dfc_pkg::*;
#(
  parameter int REG_W = 16,
  parameter logic [REG_W-1:0] BASE_RST = 16'hF003
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             autobuf_i,
  input  logic             fetch_ok_i,
  input  logic [REG_W-1:0] cfg_i,
  output logic [REG_W-1:0] rdata_o,
  output logic [REG_W-1:0] base_o,
  output logic [REG_W-1:0] off_o,
  output logic             rdy_o,
  output logic             rdy_wr_o
);
  logic [REG_W-1:0] base_q, off_q;
  logic             rdy_q;

  assign rdy_wr_o = we_i && (addr_i == RA_RDY) && wdata_i[0] && !autobuf_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= BASE_RST;
      off_q  <= '0;
      rdy_q  <= 1'b0;
    end else begin
      if (we_i && addr_i == RA_BASE) base_q <= wdata_i;
      if (we_i && addr_i == RA_OFF)  off_q  <= wdata_i;
      // a successful fetch wins over a coincident set
      if (fetch_ok_i)    rdy_q <= 1'b0;
      else if (rdy_wr_o) rdy_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (addr_i)
      RA_BASE: rdata_o = base_q;
      RA_OFF:  rdata_o = off_q;
      RA_RDY:  rdata_o = {{(REG_W-1){1'b0}}, rdy_q};
      default: rdata_o = cfg_i;
    endcase
  end

  assign base_o = base_q;
  assign off_o  = off_q;
  assign rdy_o  = rdy_q;
endmodule

// File: rtl/dfc_fsm.sv
module dfc_fsm
  import dfc_pkg::*;
#(
  parameter int REG_W   = 16,
  parameter int OWN_BIT = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             autobuf_i,
  input  logic             start_i,
  input  logic             done_i,
  input  logic             rdy_wr_i,
  input  logic             mem_valid_i,
  input  logic             mem_err_i,
  input  logic [REG_W-1:0] mem_rdata_i,
  output logic             mem_req_o,
  output logic [REG_W-1:0] cfg_o,
  output logic             fetch_ok_o,
  output logic             halted_o,
  output logic             running_o
);
  dfc_st_e          st_q, st_d;
  logic [REG_W-1:0] cfg_q;

  assign fetch_ok_o = (st_q == ST_FETCH) && mem_valid_i && !mem_err_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start_i)       st_d = autobuf_i ? ST_RUN : ST_FETCH;
                else if (rdy_wr_i) st_d = ST_FETCH;
      ST_FETCH: if (mem_valid_i)   st_d = mem_err_i ? ST_HALT : ST_CHECK;
      ST_CHECK: st_d = cfg_q[OWN_BIT] ? ST_RUN : ST_HALT;
      ST_RUN:   if (done_i)        st_d = ST_IDLE;
      ST_HALT:  if (rdy_wr_i)      st_d = ST_FETCH;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cfg_q <= '0;
    end else begin
      st_q <= st_d;
      if (fetch_ok_o) cfg_q <= mem_rdata_i;
    end
  end

  assign mem_req_o = (st_q == ST_FETCH);
  assign halted_o  = (st_q == ST_HALT);
  assign running_o = (st_q == ST_RUN);
  assign cfg_o     = cfg_q;
endmodule

// File: rtl/desc_fetch_ctrl.sv
module desc_fetch_ctrl #(
  parameter int REG_W   = 16,
  parameter int OWN_BIT = 15,
  parameter logic [REG_W-1:0] BASE_RST = 16'hF003,
  localparam int ADDR_W = 2 * REG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              autobuf_i,
  input  logic              start_i,
  input  logic              done_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_valid_i,
  input  logic              mem_err_i,
  input  logic [REG_W-1:0]  mem_rdata_i,
  output logic [REG_W-1:0]  cfg_o,
  output logic              halted_o,
  output logic              running_o
);
  logic [REG_W-1:0] base_w, off_w, cfg_w;
  logic             rdy_q, rdy_wr, fetch_ok;

  dfc_regs #(.REG_W(REG_W), .BASE_RST(BASE_RST)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .autobuf_i  (autobuf_i),
    .fetch_ok_i (fetch_ok),
    .cfg_i      (cfg_w),
    .rdata_o    (reg_rdata_o),
    .base_o     (base_w),
    .off_o      (off_w),
    .rdy_o      (rdy_q),
    .rdy_wr_o   (rdy_wr)
  );

  dfc_fsm #(.REG_W(REG_W), .OWN_BIT(OWN_BIT)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .autobuf_i   (autobuf_i),
    .start_i     (start_i),
    .done_i      (done_i),
    .rdy_wr_i    (rdy_wr),
    .mem_valid_i (mem_valid_i),
    .mem_err_i   (mem_err_i),
    .mem_rdata_i (mem_rdata_i),
    .mem_req_o   (mem_req_o),
    .cfg_o       (cfg_w),
    .fetch_ok_o  (fetch_ok),
    .halted_o    (halted_o),
    .running_o   (running_o)
  );

  assign mem_addr_o = {base_w, off_w};
  assign cfg_o      = cfg_w;
endmodule

// File: rtl/desc_fetch_ctrl_chk.sv
module desc_fetch_ctrl_chk #(
  parameter int REG_W   = 16,
  parameter int OWN_BIT = 15
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic [1:0]       reg_addr_i,
  input logic [REG_W-1:0] reg_wdata_i,
  input logic             autobuf_i,
  input logic             mem_req_o,
  input logic             mem_valid_i,
  input logic             mem_err_i,
  input logic [REG_W-1:0] mem_rdata_i,
  input logic [REG_W-1:0] cfg_o,
  input logic             halted_o,
  input logic             running_o,
  input logic             rdy_i
);
  logic rdy_set;
  assign rdy_set = reg_we_i && reg_addr_i == 2'd2 && reg_wdata_i[0] && !autobuf_i;

  // R2
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_valid_i |=> mem_req_o);

  // R5
  state_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(halted_o && running_o) && !(mem_req_o && (halted_o || running_o)));

  // R4
  own_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_valid_i && !mem_err_i && mem_rdata_i[OWN_BIT] |=> ##1 running_o);

  // R5
  own_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_valid_i && !mem_err_i && !mem_rdata_i[OWN_BIT] |=> ##1 halted_o);

  // R7
  err_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_valid_i && mem_err_i |=> halted_o && $stable(cfg_o));

  // R7
  rdy_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_valid_i && !mem_err_i |=> !rdy_i);

  // R7
  rdy_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_valid_i && mem_err_i && rdy_i |=> rdy_i);

  // R6
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o && rdy_set |=> mem_req_o);

  // R9
  autobuf_rdy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    autobuf_i && !rdy_i |=> !rdy_i);
endmodule

bind desc_fetch_ctrl desc_fetch_ctrl_chk #(.REG_W(REG_W), .OWN_BIT(OWN_BIT)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .autobuf_i   (autobuf_i),
  .mem_req_o   (mem_req_o),
  .mem_valid_i (mem_valid_i),
  .mem_err_i   (mem_err_i),
  .mem_rdata_i (mem_rdata_i),
  .cfg_o       (cfg_o),
  .halted_o    (halted_o),
  .running_o   (running_o),
  .rdy_i       (rdy_q)
);

// File: tb/desc_fetch_ctrl_tb.sv
module desc_fetch_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        autobuf = 1'b0, start = 1'b0, done = 1'b0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_valid = 1'b0, mem_err = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic [15:0] cfg;
  logic        halted, running;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  desc_fetch_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .autobuf_i(autobuf), .start_i(start), .done_i(done),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_valid_i(mem_valid), .mem_err_i(mem_err),
    .mem_rdata_i(mem_rdata), .cfg_o(cfg), .halted_o(halted), .running_o(running)
  );

  // behavioural reference: 0 idle, 1 fetching, 2 checking, 3 running, 4 halted
  int          m_mode = 0;
  logic [15:0] m_base = 16'hF003, m_off = '0, m_cfg = '0;
  bit          m_rdy = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_base = 16'hF003; m_off = '0; m_cfg = '0; m_rdy = 1'b0;
    end else begin
      bit sw_go, got;
      int nxt;
      sw_go = reg_we && reg_addr == 2'd2 && reg_wdata[0] && !autobuf;
      got   = (m_mode == 1) && mem_valid && !mem_err;
      nxt   = m_mode;
      if (m_mode == 0 && start) nxt = autobuf ? 3 : 1;
      else if ((m_mode == 0 || m_mode == 4) && sw_go) nxt = 1;
      else if (m_mode == 1 && mem_valid) nxt = mem_err ? 4 : 2;
      else if (m_mode == 2) nxt = m_cfg[15] ? 3 : 4;
      else if (m_mode == 3 && done) nxt = 0;
      if (got) m_cfg = mem_rdata;
      if (got) m_rdy = 1'b0;
      else if (sw_go) m_rdy = 1'b1;
      if (reg_we && reg_addr == 2'd0) m_base = reg_wdata;
      if (reg_we && reg_addr == 2'd1) m_off = reg_wdata;
      m_mode = nxt;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      logic [15:0] exp_rd;
      case (reg_addr)
        2'd0: exp_rd = m_base;
        2'd1: exp_rd = m_off;
        2'd2: exp_rd = {15'd0, m_rdy};
        default: exp_rd = m_cfg;
      endcase
      chk(mem_req === (m_mode == 1), "R2", "mem_req", 32'(mem_req), 32'(m_mode == 1));
      chk(mem_addr === {m_base, m_off}, "R2", "mem_addr", mem_addr, {m_base, m_off});
      chk(cfg === m_cfg, "R3", "cfg", 32'(cfg), 32'(m_cfg));
      chk(running === (m_mode == 3), "R4", "running", 32'(running), 32'(m_mode == 3));
      chk(halted === (m_mode == 4), "R5", "halted", 32'(halted), 32'(m_mode == 4));
      chk(reg_rdata === exp_rd, "R8", "rdata", 32'(reg_rdata), 32'(exp_rd));
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [15:0] exp, input string tag);
    reg_addr = a;
    @(negedge clk);
    chk(reg_rdata === exp, tag, "reg read", 32'(reg_rdata), 32'(exp));
    tick();
  endtask

  task automatic pulse_start();
    start = 1'b1; tick(); start = 1'b0;
  endtask

  task automatic pulse_done();
    done = 1'b1; tick(); done = 1'b0;
  endtask

  task automatic reply(input int lat, input logic [15:0] d, input bit e);
    repeat (lat) tick();
    mem_valid = 1'b1; mem_rdata = d; mem_err = e;
    tick();
    mem_valid = 1'b0; mem_err = 1'b0;
  endtask

  task automatic outs_chk(input bit r, input bit h, input bit q, input string tag);
    @(negedge clk);
    chk(running === r, tag, "running", 32'(running), 32'(r));
    chk(halted === h, tag, "halted", 32'(halted), 32'(h));
    chk(mem_req === q, tag, "mem_req", 32'(mem_req), 32'(q));
    tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    rd_chk(2'd0, 16'hF003, "R1");
    rd_chk(2'd1, 16'h0000, "R1");
    rd_chk(2'd2, 16'h0000, "R1");
    rd_chk(2'd3, 16'h0000, "R1");
    outs_chk(0, 0, 0, "R1");

    // R9 autobuffer: ready inert, start runs directly
    autobuf = 1'b1; tick();
    wr(2'd2, 16'h0001);
    outs_chk(0, 0, 0, "R9");
    rd_chk(2'd2, 16'h0000, "R9");
    pulse_start();
    outs_chk(1, 0, 0, "R9");
    pulse_done();
    autobuf = 1'b0; tick();

    // R2 R3 R4 owned descriptor
    wr(2'd1, 16'h0040);
    wr(2'd0, 16'h1234);
    pulse_start();
    @(negedge clk);
    chk(mem_req === 1'b1, "R11", "req after start", 32'(mem_req), 32'd1);
    chk(mem_addr === 32'h1234_0040, "R2", "fetch addr", mem_addr, 32'h1234_0040);
    reply(2, 16'h8005, 1'b0);
    @(negedge clk);
    chk(cfg === 16'h8005 && !running, "R11", "check cycle", 32'(cfg), 32'h8005);
    tick();
    outs_chk(1, 0, 0, "R4");
    rd_chk(2'd3, 16'h8005, "R3");
    pulse_done();
    outs_chk(0, 0, 0, "R4");

    // R5 not owned
    pulse_start();
    reply(1, 16'h0007, 1'b0);
    tick();
    outs_chk(0, 1, 0, "R5");
    outs_chk(0, 1, 0, "R5");

    // R6 R8 restart, R10 absorbed write, R7 error
    wr(2'd2, 16'hFFFF);
    rd_chk(2'd2, 16'h0001, "R8");
    @(negedge clk);
    chk(mem_req === 1'b1, "R6", "refetch req", 32'(mem_req), 32'd1);
    tick();
    wr(2'd2, 16'h0001);
    reply(0, 16'h9999, 1'b1);
    outs_chk(0, 1, 0, "R7");
    rd_chk(2'd2, 16'h0001, "R7");
    rd_chk(2'd3, 16'h0007, "R7");
    outs_chk(0, 1, 0, "R10");

    // R7 successful fetch of unowned word clears ready
    wr(2'd2, 16'h0001);
    reply(0, 16'h0003, 1'b0);
    tick();
    outs_chk(0, 1, 0, "R5");
    rd_chk(2'd2, 16'h0000, "R7");

    // R8 write of zero and write to config are ignored
    wr(2'd2, 16'h0000);
    outs_chk(0, 1, 0, "R8");
    rd_chk(2'd2, 16'h0000, "R8");
    wr(2'd3, 16'hAAAA);
    rd_chk(2'd3, 16'h0003, "R8");

    // R10 ready write while running starts nothing
    wr(2'd2, 16'h0001);
    reply(1, 16'h8001, 1'b0);
    tick();
    wr(2'd2, 16'h0001);
    outs_chk(1, 0, 0, "R10");
    rd_chk(2'd2, 16'h0001, "R10");
    pulse_done();
    outs_chk(0, 0, 0, "R10");

    // R6 ready write from idle fetches and clears the flag
    wr(2'd2, 16'h0001);
    @(negedge clk);
    chk(mem_req === 1'b1, "R6", "idle refetch", 32'(mem_req), 32'd1);
    tick();
    reply(0, 16'h8000, 1'b0);
    tick();
    outs_chk(1, 0, 0, "R6");
    rd_chk(2'd2, 16'h0000, "R7");
    pulse_done();
    tick();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule